// File: doc/BRIEF.md
# Three-Wire Serial Command Transceiver

This block is a serial master that exchanges one 32-bit word in each direction over three wires. It drives a serial clock and a data line and listens on a returned data line. A user-side start strobe launches a transfer. The block frames the transfer with a start condition and a stop condition. Between them it sends the command word most significant bit first and collects one reply bit per clock pulse. When the transfer ends, it publishes a status word and raises a one-cycle completion pulse.

Every line change is separated by one step of `STEP_CYCLES` system clocks, counted by an internal timer. The returned data passes through a flop synchronizer before it is used. The top two bits of the published status do not carry the reply. They echo the two most significant bits of the command, the page selector, so the status stays paired with the request that produced it.

Top module: `sercmd_xcvr`

## Requirements
- R1: After reset, and whenever no transfer is running, `serClk` and `serDout` are both 1, `busy` is 0. After reset `statusWord` is 0.
- R2: A `startReq` seen while idle sets `busy` on the next clock edge. In the same edge `serDout` falls while `serClk` stays 1. One step later `serClk` falls while `serDout` is still 0.
- R3: The command word latched at the accepted start is sent most significant bit first, one bit per `serClk` high pulse. During the bit phase `serDout` never changes while `serClk` is high.
- R4: A transfer produces exactly `WORD_W` rising edges of `serClk` for data, plus one more rising edge for the stop condition.
- R5: Each reply bit is taken from the synchronized `serDin` one step after the falling edge of `serClk`. It is shifted in from the least significant end, so the first sampled bit lands in bit `WORD_W-1`. Status bits `WORD_W-3` down to 0 hold the last `WORD_W-2` sampled bits.
- R6: The stop condition raises `serClk` while `serDout` is 0. Exactly one step later `serDout` rises, in the same cycle as `donePulse`.
- R7: Status bits `WORD_W-1:WORD_W-2` equal the same two bits of the command latched at the start, whatever reply was received.
- R8: `donePulse` is high for one cycle, in the cycle where `busy` has just fallen. `statusWord` changes only in that cycle and holds its value until the next completion.
- R9: `startReq` has no effect while `busy` is 1. The running transfer keeps its command and its length, and no second transfer follows.
- R10: From the rise of `busy` to `donePulse`, a transfer lasts exactly `(3*WORD_W + 3) * STEP_CYCLES` clocks. `STEP_CYCLES` must be at least 2, so that a reply bit changed at a clock rise clears the synchronizer before it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Launch a transfer when idle |
| cmdWord | input | WORD_W | Command word to send, sampled with the accepted start |
| busy | output | 1 | Transfer in progress |
| donePulse | output | 1 | One-cycle completion pulse |
| statusWord | output | WORD_W | Received reply, with page bits taken from the command |
| serClk | output | 1 | Serial clock line |
| serDout | output | 1 | Serial data toward the peripheral |
| serDin | input | 1 | Serial data from the peripheral, asynchronous |

## Verification
The bench builds the block with `WORD_W` = 32 and `STEP_CYCLES` = 2, the smallest legal step. At that step a reply bit that changes right after a clock rise reaches the sample point with only the synchronizer's margin, so any extra latency in the input path shows up as a wrong status bit. The short step also keeps each transfer near two hundred cycles. That leaves room for dozens of random command and reply pairs, plus directed cases: all-zero and all-one words, page bits that disagree with the reply, and start strobes fired in the middle of a transfer.

// File: rtl/sercmd_pkg.sv
`timescale 1ns/1ps
package sercmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_OPEN_A = 3'd1,
    ST_OPEN_B = 3'd2,
    ST_SETUP  = 3'd3,
    ST_HIGH   = 3'd4,
    ST_LOW    = 3'd5,
    ST_CLOSE  = 3'd6
  } seqState_t;

  // strobes from the sequencer to the datapath, all single-cycle
  typedef struct packed {
    logic loadCmd;
    logic sdoLow;
    logic sdoHigh;
    logic sdoBit;
    logic sckLow;
    logic sckHigh;
    logic sample;
    logic finish;
  } lineStb_t;

endpackage

// File: rtl/sercmd_sync.sv
`timescale 1ns/1ps
module sercmd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic dOut
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '0;
        else       chain <= dIn;
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], dIn};
    end
  endgenerate

  assign dOut = chain[STAGES-1];
endmodule

// File: rtl/sercmd_ctrl.sv
`timescale 1ns/1ps
module sercmd_ctrl
  import sercmd_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int STEP_CYCLES = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  output logic     busy,
  output lineStb_t stb
);
  localparam int TMR_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(STEP_CYCLES - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORD_W - 1);

  seqState_t        state, stateNxt;
  logic [TMR_W-1:0] stepTmr;
  logic [IDX_W-1:0] bitIdx;
  logic             stepEnd;
  logic             lastBit;

  assign stepEnd = (stepTmr == TMR_LAST);
  assign lastBit = (bitIdx == IDX_LAST);
  assign busy    = (state != ST_IDLE);

  always_comb begin
    stateNxt = state;
    stb      = '0;
    unique case (state)
      ST_IDLE: if (startReq) begin
        stateNxt    = ST_OPEN_A;
        stb.loadCmd = 1'b1;
        stb.sdoLow  = 1'b1;
      end
      ST_OPEN_A: if (stepEnd) begin
        stateNxt   = ST_OPEN_B;
        stb.sckLow = 1'b1;
      end
      ST_OPEN_B: if (stepEnd) begin
        stateNxt   = ST_SETUP;
        stb.sdoBit = 1'b1;
      end
      ST_SETUP: if (stepEnd) begin
        stateNxt    = ST_HIGH;
        stb.sckHigh = 1'b1;
      end
      ST_HIGH: if (stepEnd) begin
        stateNxt   = ST_LOW;
        stb.sckLow = 1'b1;
      end
      ST_LOW: if (stepEnd) begin
        stb.sample = 1'b1;
        if (lastBit) begin
          stateNxt    = ST_CLOSE;
          stb.sckHigh = 1'b1;
          stb.sdoLow  = 1'b1;
        end else begin
          stateNxt   = ST_SETUP;
          stb.sdoBit = 1'b1;
        end
      end
      ST_CLOSE: if (stepEnd) begin
        stateNxt    = ST_IDLE;
        stb.sdoHigh = 1'b1;
        stb.finish  = 1'b1;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;

  // step timer: free-runs inside every non-idle state, wraps on each step
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                         stepTmr <= '0;
    else if (state == ST_IDLE || stepEnd) stepTmr <= '0;
    else                               stepTmr <= stepTmr + 1'b1;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)           bitIdx <= '0;
    else if (stb.loadCmd) bitIdx <= '0;
    else if (stb.sample)  bitIdx <= bitIdx + 1'b1;
endmodule

// File: rtl/sercmd_dp.sv
`timescale 1ns/1ps
module sercmd_dp
  import sercmd_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int PAGE_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  lineStb_t          stb,
  input  logic [WORD_W-1:0] cmdIn,
  input  logic              serDin,
  output logic              serClk,
  output logic              serDout,
  output logic              doneOut,
  output logic [WORD_W-1:0] statusOut
);
  localparam int RX_W = WORD_W - PAGE_W;

  logic [WORD_W-1:0] cmdShift;
  logic [PAGE_W-1:0] pageHold;
  logic [RX_W-1:0]   rxShift;
  logic              dinSync;

  sercmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (serDin),
    .dOut (dinSync)
  );

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      cmdShift <= '0;
      pageHold <= '0;
    end else if (stb.loadCmd) begin
      cmdShift <= cmdIn;
      pageHold <= cmdIn[WORD_W-1 -: PAGE_W];
    end else if (stb.sdoBit) begin
      cmdShift <= {cmdShift[WORD_W-2:0], 1'b0};
    end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)            serClk <= 1'b1;
    else if (stb.sckLow)  serClk <= 1'b0;
    else if (stb.sckHigh) serClk <= 1'b1;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)            serDout <= 1'b1;
    else if (stb.sdoLow)  serDout <= 1'b0;
    else if (stb.sdoHigh) serDout <= 1'b1;
    else if (stb.sdoBit)  serDout <= cmdShift[WORD_W-1];

  // only the low reply bits survive; the page bits come from the command
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)           rxShift <= '0;
    else if (stb.sample) rxShift <= {rxShift[RX_W-2:0], dinSync};

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      statusOut <= '0;
      doneOut   <= 1'b0;
    end else begin
      doneOut <= stb.finish;
      if (stb.finish) statusOut <= {pageHold, rxShift};
    end
endmodule

// File: rtl/sercmd_xcvr.sv
`timescale 1ns/1ps
module sercmd_xcvr
  import sercmd_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int PAGE_W      = 2,
  parameter int STEP_CYCLES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [WORD_W-1:0] cmdWord,
  output logic              busy,
  output logic              donePulse,
  output logic [WORD_W-1:0] statusWord,
  output logic              serClk,
  output logic              serDout,
  input  logic              serDin
);
  lineStb_t stb;

  sercmd_ctrl #(
    .WORD_W      (WORD_W),
    .STEP_CYCLES (STEP_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .busy     (busy),
    .stb      (stb)
  );

  sercmd_dp #(
    .WORD_W      (WORD_W),
    .PAGE_W      (PAGE_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cmdIn     (cmdWord),
    .serDin    (serDin),
    .serClk    (serClk),
    .serDout   (serDout),
    .doneOut   (donePulse),
    .statusOut (statusWord)
  );
endmodule

// File: rtl/sercmd_chk.sv
`timescale 1ns/1ps
module sercmd_chk #(
  parameter int WORD_W = 32,
  parameter int PAGE_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReq,
  input logic [PAGE_W-1:0] cmdPage,
  input logic              busy,
  input logic              donePulse,
  input logic [WORD_W-1:0] statusWord,
  input logic              serClk,
  input logic              serDout
);
  logic [PAGE_W-1:0] pageCap;
  logic              sckPrev;
  int unsigned       riseCnt;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      pageCap <= '0;
      sckPrev <= 1'b1;
      riseCnt <= 0;
    end else begin
      sckPrev <= serClk;
      if (startReq && !busy) begin
        pageCap <= cmdPage;
        riseCnt <= 0;
      end else if (serClk && !sckPrev) begin
        riseCnt <= riseCnt + 1;
      end
    end

  // R1
  idle_lines_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (serClk && serDout));

  // R2
  start_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (serClk && !serDout));

  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && serClk && $past(serClk)) |-> $stable(serDout));

  // R4
  clock_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (riseCnt == WORD_W + 1));

  // R6
  stop_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(serDout) && !busy) |-> (serClk && donePulse));

  // R7
  page_echo_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (statusWord[WORD_W-1 -: PAGE_W] == pageCap));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> ($fell(busy) && !busy));

  // R8
  status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !donePulse |-> $stable(statusWord));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq) |=> (busy || donePulse));
endmodule

bind sercmd_xcvr sercmd_chk #(
  .WORD_W (WORD_W),
  .PAGE_W (PAGE_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startReq   (startReq),
  .cmdPage    (cmdWord[WORD_W-1 -: PAGE_W]),
  .busy       (busy),
  .donePulse  (donePulse),
  .statusWord (statusWord),
  .serClk     (serClk),
  .serDout    (serDout)
);

// File: tb/sercmd_xcvr_tb_top.sv
`timescale 1ns/1ps
module sercmd_xcvr_tb_top;
  localparam int W    = 32;
  localparam int STEP = 2;
  localparam int XFER_LEN = (3 * W + 3) * STEP;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0;
  logic [W-1:0]  cmdWord = '0;
  logic          busy, donePulse, serClk, serDout;
  logic [W-1:0]  statusWord;
  logic          serDin = 1'b0;

  int nChecks = 0;
  int nFail   = 0;

  always #2.5 clk = ~clk;

  sercmd_xcvr #(
    .WORD_W      (W),
    .PAGE_W      (2),
    .STEP_CYCLES (STEP),
    .SYNC_STAGES (2)
  ) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .cmdWord    (cmdWord),
    .busy       (busy),
    .donePulse  (donePulse),
    .statusWord (statusWord),
    .serClk     (serClk),
    .serDout    (serDout),
    .serDin     (serDin)
  );

  // peripheral model and line monitor, run 1 ns after each rising edge
  logic [W-1:0] slaveReply = '0;
  logic [W-1:0] slaveCmd   = '0;
  logic         inXfer = 1'b0;
  logic         prevSck = 1'b1, prevSdo = 1'b1, prevBusy = 1'b0;
  int           cyc = 0, bitCnt = 0, riseCnt = 0, lastRiseCyc = 0;
  int           stopGap = 0, badEdge = 0, busyLen = 0;

  always begin
    @(posedge clk);
    #1;
    cyc++;
    if (busy && !prevBusy) busyLen = 1;
    else if (busy)         busyLen++;
    if (serClk && prevSck && prevSdo && !serDout && !inXfer) begin
      inXfer  = 1'b1;
      bitCnt  = 0;
      riseCnt = 0;
      badEdge = 0;
    end else if (inXfer && serClk && !prevSck) begin
      riseCnt++;
      lastRiseCyc = cyc;
      if (bitCnt < W) begin
        slaveCmd = {slaveCmd[W-2:0], serDout};
        serDin   = slaveReply[W-1-bitCnt];
        bitCnt++;
      end
    end else if (inXfer && serClk && prevSck && serDout != prevSdo) begin
      if (serDout && riseCnt == W + 1) begin
        inXfer  = 1'b0;
        stopGap = cyc - lastRiseCyc;
      end else begin
        badEdge++;
      end
    end
    prevSck  = serClk;
    prevSdo  = serDout;
    prevBusy = busy;
  end

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] expStatus(input logic [W-1:0] c, input logic [W-1:0] r);
    return {c[W-1:W-2], r[W-3:0]};
  endfunction

  task automatic doXfer(input logic [W-1:0] cmd, input logic [W-1:0] reply, input bit poke);
    int waitCnt;
    logic [W-1:0] held;
    slaveReply = reply;
    @(negedge clk);
    cmdWord  = cmd;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chk(busy && serClk && !serDout, "R2 start", {busy, serClk, serDout}, 3'b110);
    repeat (STEP) @(negedge clk);
    chk(!serClk && !serDout, "R2 clock low", {serClk, serDout}, 2'b00);
    if (poke) begin
      repeat (20) @(negedge clk);
      cmdWord  = ~cmd;
      startReq = 1'b1;
      repeat (3) @(negedge clk);
      startReq = 1'b0;
    end
    waitCnt = 0;
    while (!donePulse && waitCnt < 4 * XFER_LEN) begin
      @(negedge clk);
      waitCnt++;
    end
    chk(donePulse, "R8 done seen", donePulse, 1);
    chk(slaveCmd == cmd, "R3 command bits", slaveCmd, cmd);
    chk(badEdge == 0, "R3 data stable", badEdge, 0);
    chk(riseCnt == W + 1, "R4 clock rises", riseCnt, W + 1);
    chk(statusWord[W-3:0] == reply[W-3:0], "R5 reply bits", statusWord, expStatus(cmd, reply));
    chk(statusWord[W-1:W-2] == cmd[W-1:W-2], "R7 page bits", statusWord[W-1:W-2], cmd[W-1:W-2]);
    chk(stopGap == STEP && serClk && serDout, "R6 stop", stopGap, STEP);
    chk(busyLen == XFER_LEN, "R10 length", busyLen, XFER_LEN);
    chk(!busy, "R8 busy low", busy, 0);
    held = statusWord;
    @(negedge clk);
    chk(!donePulse, "R8 single pulse", donePulse, 0);
    cmdWord = ~cmdWord;
    repeat (6) @(negedge clk);
    chk(statusWord == held, "R8 status hold", statusWord, held);
    chk(!busy && serClk && serDout, "R1 idle lines", {busy, serClk, serDout}, 3'b011);
    if (poke) chk(!busy && !donePulse, "R9 no extra transfer", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog R10 actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EC0_0D1E);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !donePulse && serClk && serDout, "R1 reset lines",
        {busy, donePulse, serClk, serDout}, 4'b0011);
    chk(statusWord == '0, "R1 reset status", statusWord, '0);
    // directed corners
    doXfer(32'h0000_0000, 32'hFFFF_FFFF, 1'b0);
    doXfer(32'hFFFF_FFFF, 32'h0000_0000, 1'b0);
    doXfer(32'hA5A5_5A5A, 32'h2000_0001, 1'b0);
    doXfer(32'h4000_0000, 32'hBFFF_FFFF, 1'b1);   // R9 start while busy
    doXfer(32'h8000_0001, 32'h5555_AAAA, 1'b1);
    for (int i = 0; i < 30; i++) begin
      doXfer($urandom, $urandom, ($urandom % 4) == 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule